// File: doc/BRIEF.md
# Word/Byte Load-Store Unit with Misaligned Rotation

This block carries out one memory transfer for a processor core: a 32-bit word or an unsigned byte, as a load or a store. It picks the offset from a 12-bit immediate or from an already shifted register value. It adds the offset to the base or subtracts it from the base, with wrap-around, and chooses between pre-indexed and post-indexed addressing. It then runs one bus access of the selected size.

After the access, the block writes its results back through a single register write port, in a fixed order. The updated base comes first, if writeback applies. The loaded value comes second, if the transfer is a load. Because of this order, a load whose destination is the base register always leaves the loaded value in that register.

A word load at a misaligned address reads the aligned word that contains the address. It then rotates that word right by the byte offset. A byte load reads the exact byte and zero-extends it. A word store writes the whole register to the aligned address. A byte store copies its low byte onto all four lanes and enables only the addressed lane. The core issues a transfer with `req` while `ready` is high. The block raises `done` for one cycle when the transfer is finished.

Top module: `lsu_word_byte`

## Requirements
- R1: When `imm_sel` is 0 the offset is `imm12` zero-extended to 32 bits; when `imm_sel` is 1 the offset is `shifted_off` unchanged.
- R2: The modified base is `base_val + offset` when `up` is 1 and `base_val - offset` when `up` is 0, both modulo 2^32.
- R3: The transfer address is the modified base when `pre` is 1 and the unmodified `base_val` when `pre` is 0.
- R4: The modified base is written to register `base_idx` exactly when `pre` is 0, or when `pre` and `wb` are both 1; otherwise no base write occurs.
- R5: A word transfer (`byte_op`=0) drives `bus_addr` with bits 1:0 cleared and `bus_be`=4'b1111; a word load returns the bus word rotated right by 8 × (address bits 1:0).
- R6: A byte load (`byte_op`=1) drives the exact transfer address and returns bus byte lane address[1:0] (bits 8a+7:8a) zero-extended to 32 bits.
- R7: A word store drives `bus_we`=1 and `bus_wdata` equal to `store_val`.
- R8: A byte store drives `bus_wdata` as `store_val[7:0]` repeated on all four lanes, and `bus_be` one-hot with bit address[1:0] set.
- R9: Register writes appear one per cycle on `reg_we`/`reg_idx`/`reg_wdata`: the base write first, then the load result to `dst_idx`; a store makes no destination write, so when `dst_idx` equals `base_idx` on a load the loaded value is the last write.
- R10: `ready` is high only while idle; a transfer is accepted on a clock edge with `req` and `ready` high; `bus_req` is held with a stable address until a cycle with `bus_ready` high; `done` is a single-cycle pulse after the last register write.
- R11: After reset `ready`=1 and `bus_req`, `reg_we` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transfer |
| ready | output | 1 | Idle, able to take a request |
| imm_sel | input | 1 | 0: immediate offset, 1: shifted register offset |
| pre | input | 1 | Pre-indexed addressing |
| up | input | 1 | Add offset (1) or subtract it (0) |
| wb | input | 1 | Write back the base when pre-indexed |
| byte_op | input | 1 | Byte transfer (1) or word transfer (0) |
| load | input | 1 | Load (1) or store (0) |
| base_idx | input | 4 | Base register number |
| dst_idx | input | 4 | Destination/source register number |
| imm12 | input | 12 | Immediate offset |
| shifted_off | input | 32 | Register offset already shifted by the shifter |
| base_val | input | 32 | Base register value |
| store_val | input | 32 | Value to store |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus write |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_ready | input | 1 | Bus access completes this cycle |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 4 | Register written |
| reg_wdata | output | 32 | Register write data |
| done | output | 1 | Transfer finished (one cycle) |

## Verification
The bench sweeps every combination of the six mode bits against each of the four base alignments, with varying bus latency. Base and offset values are chosen so that addition and subtraction wrap past zero; a design that dropped the carry or sign-extended the immediate would return a wrong base and a wrong address. Misaligned word loads are compared against a rotation computed in the bench. A design that shifted the word instead of rotating it would lose the upper bytes, and one that used the unaligned address would miss the aligned-address check. Half of the loads name the base as their destination, so a design that ordered the two writes the wrong way round would leave the new base in place of the loaded data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned LANE_W  = $clog2(LANES);

    typedef struct packed {
        logic imm_sel;
        logic pre;
        logic up;
        logic wb;
        logic byte_op;
        logic load;
    } xfer_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BUS   = 3'd1,
        ST_WBASE = 3'd2,
        ST_WDEST = 3'd3,
        ST_DONE  = 3'd4
    } xfer_state_t;

    function automatic logic [DATA_W-1:0] rot_right_bytes(
        input logic [DATA_W-1:0] v,
        input logic [LANE_W-1:0] nb
    );
        logic [2*DATA_W-1:0] dbl;
        dbl = {v, v} >> (8 * nb);
        return dbl[DATA_W-1:0];
    endfunction

    function automatic logic [LANES-1:0] lane_onehot(input logic [LANE_W-1:0] nb);
        return LANES'(1) << nb;
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 12
) (
    input  xfer_mode_t        mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] shifted,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [ADDR_W-1:0] new_base,
    output logic              base_upd
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset    = mode.imm_sel ? shifted : ADDR_W'(imm);
        new_base  = mode.up ? (base + offset) : (base - offset);
        xfer_addr = mode.pre ? new_base : base;
        base_upd  = !mode.pre || mode.wb;
    end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_pkg::*;
(
    input  logic                 byte_op,
    input  logic [LANE_W-1:0]    lane,
    input  logic [DATA_W-1:0]    rdata,
    input  logic [DATA_W-1:0]    store_val,
    output logic [DATA_W-1:0]    ld_val,
    output logic [DATA_W-1:0]    wdata,
    output logic [LANES-1:0]     be
);
    logic [DATA_W-1:0] rotated;

    assign rotated = rot_right_bytes(rdata, lane);

    always_comb begin
        if (byte_op) begin
            ld_val = DATA_W'(rotated[7:0]);
            be     = lane_onehot(lane);
        end else begin
            ld_val = rotated;
            be     = '1;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata[8*g +: 8] = byte_op ? store_val[7:0] : store_val[8*g +: 8];
    end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
    import lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        bus_ready,
    input  logic        base_upd,
    input  logic        is_load,
    output xfer_state_t state
);
    xfer_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_BUS;
            ST_BUS:   if (bus_ready) nxt = base_upd ? ST_WBASE : (is_load ? ST_WDEST : ST_DONE);
            ST_WBASE: nxt = is_load ? ST_WDEST : ST_DONE;
            ST_WDEST: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/lsu_word_byte.sv
module lsu_word_byte
    import lsu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 12,
    parameter int unsigned RIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              ready,
    input  logic              imm_sel,
    input  logic              pre,
    input  logic              up,
    input  logic              wb,
    input  logic              byte_op,
    input  logic              load,
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [ADDR_W-1:0] shifted_off,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DATA_W-1:0] store_val,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              reg_we,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              done
);
    xfer_mode_t        mode_q;
    logic [RIDX_W-1:0] bidx_q, didx_q;
    logic [IMM_W-1:0]  imm_q;
    logic [ADDR_W-1:0] shoff_q, base_q;
    logic [DATA_W-1:0] sval_q, rdata_q;
    xfer_state_t       state;
    logic              start;
    logic [ADDR_W-1:0] xfer_addr, new_base;
    logic              base_upd;
    logic [DATA_W-1:0] ld_val;

    assign ready = (state == ST_IDLE);
    assign start = req && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            bidx_q  <= '0;
            didx_q  <= '0;
            imm_q   <= '0;
            shoff_q <= '0;
            base_q  <= '0;
            sval_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                mode_q  <= '{imm_sel: imm_sel, pre: pre, up: up, wb: wb,
                             byte_op: byte_op, load: load};
                bidx_q  <= base_idx;
                didx_q  <= dst_idx;
                imm_q   <= imm12;
                shoff_q <= shifted_off;
                base_q  <= base_val;
                sval_q  <= store_val;
            end
            if (state == ST_BUS && bus_ready) rdata_q <= bus_rdata;
        end
    end

    lsu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
        .mode      (mode_q),
        .imm       (imm_q),
        .shifted   (shoff_q),
        .base      (base_q),
        .xfer_addr (xfer_addr),
        .new_base  (new_base),
        .base_upd  (base_upd)
    );

    lsu_align u_align (
        .byte_op   (mode_q.byte_op),
        .lane      (xfer_addr[LANE_W-1:0]),
        .rdata     (rdata_q),
        .store_val (sval_q),
        .ld_val    (ld_val),
        .wdata     (bus_wdata),
        .be        (bus_be)
    );

    lsu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .bus_ready (bus_ready),
        .base_upd  (base_upd),
        .is_load   (mode_q.load),
        .state     (state)
    );

    always_comb begin
        bus_req  = (state == ST_BUS);
        bus_we   = bus_req && !mode_q.load;
        bus_addr = mode_q.byte_op ? xfer_addr
                                  : {xfer_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        reg_we   = (state == ST_WBASE) || (state == ST_WDEST);
        reg_idx  = (state == ST_WBASE) ? bidx_q : didx_q;
        reg_wdata = (state == ST_WBASE) ? new_base : ld_val;
        done     = (state == ST_DONE);
    end
endmodule

// File: rtl/lsu_word_byte_chk.sv
module lsu_word_byte_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              reg_we,
    input logic              done
);
    p_word_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_be == 4'hF) |-> (bus_addr[1:0] == 2'b00));

    p_lane_enable_r8: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_be == 4'hF || $countones(bus_be) == 1));

    p_byte_replicate_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && $countones(bus_be) == 1) |->
        (bus_wdata[7:0] == bus_wdata[15:8] && bus_wdata[7:0] == bus_wdata[23:16]
         && bus_wdata[7:0] == bus_wdata[31:24]));

    p_bus_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!bus_req && !reg_we && !done));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind lsu_word_byte lsu_word_byte_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .reg_we    (reg_we),
    .done      (done)
);

// File: tb/sim_lsu_word_byte.sv
module sim_lsu_word_byte;
    logic        clk = 0;
    logic        rst = 1;
    logic        req = 0;
    logic        ready;
    logic        imm_sel = 0, pre = 0, up = 0, wb = 0, byte_op = 0, load = 0;
    logic [3:0]  base_idx = 0, dst_idx = 0;
    logic [11:0] imm12 = 0;
    logic [31:0] shifted_off = 0, base_val = 0, store_val = 0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata = 0;
    logic        bus_ready = 0;
    logic        reg_we;
    logic [3:0]  reg_idx;
    logic [31:0] reg_wdata;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit wd_hit = 0;

    always #2.5 clk = ~clk;

    lsu_word_byte u0 (.*);

    task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5C3, ~a[15:0] ^ 16'h0F1E} ^ {a[31:16], a[31:16]};
    endfunction

    task automatic run_op(input logic [5:0] m, input logic [31:0] base, input logic [11:0] imm,
                          input logic [31:0] shoff, input logic [31:0] sval,
                          input logic [3:0] rn, input logic [3:0] rd, input int lat);
        logic [31:0] off, modb, addr, aw, exp_ld, exp_wd;
        logic [3:0]  exp_be;
        bit do_wb, seen_bus, fin;
        int waitc, nw;
        logic [3:0]  wi [2];
        logic [31:0] wv [2];
        logic [31:0] last_val;
        off   = m[5] ? shoff : {20'd0, imm};
        modb  = m[3] ? base + off : base - off;
        addr  = m[4] ? modb : base;
        do_wb = !m[4] || m[2];
        aw    = {addr[31:2], 2'b00};
        if (m[1]) exp_ld = {24'd0, 8'(mem_word(aw) >> (8 * addr[1:0]))};
        else      exp_ld = (mem_word(aw) >> (8 * addr[1:0])) | (mem_word(aw) << (32 - 8 * addr[1:0]));
        if (addr[1:0] == 0 && !m[1]) exp_ld = mem_word(aw);
        exp_be = m[1] ? (4'b0001 << addr[1:0]) : 4'hF;
        exp_wd = m[1] ? {4{sval[7:0]}} : sval;

        @(negedge clk);
        chk(ready === 1'b1, "R10 ready idle", {31'd0, ready}, 32'd1);
        {imm_sel, pre, up, wb, byte_op, load} = m;
        base_val = base; imm12 = imm; shifted_off = shoff; store_val = sval;
        base_idx = rn; dst_idx = rd; req = 1;
        @(negedge clk);
        req = 0;
        seen_bus = 0; fin = 0; waitc = 0; nw = 0;
        for (int c = 0; c < 40 && !fin; c++) begin
            if (c > 0) @(negedge clk);
            bus_ready = 0;
            if (bus_req) begin
                if (!seen_bus) begin
                    seen_bus = 1;
                    chk(bus_addr === (m[1] ? addr : aw), "R1 R2 R3 R5 R6 address", bus_addr, m[1] ? addr : aw);
                    chk(bus_be === exp_be, "R5 R8 byte enable", {28'd0, bus_be}, {28'd0, exp_be});
                    chk(bus_we === !m[0], "R7 write strobe", {31'd0, bus_we}, {31'd0, !m[0]});
                    if (!m[0]) chk(bus_wdata === exp_wd, "R7 R8 write data", bus_wdata, exp_wd);
                end
                if (waitc >= lat) begin
                    bus_ready = 1;
                    bus_rdata = m[0] ? mem_word(bus_addr & 32'hFFFF_FFFC) : 32'hDEAD_BEEF;
                end
                waitc++;
            end
            if (reg_we) begin
                if (nw < 2) begin wi[nw] = reg_idx; wv[nw] = reg_wdata; end
                nw++;
            end
            if (done) fin = 1;
        end
        bus_ready = 0;
        chk(fin, "R10 done", {31'd0, fin}, 32'd1);
        chk(seen_bus, "R10 bus access", {31'd0, seen_bus}, 32'd1);
        chk(nw == int'(do_wb) + int'(m[0]), "R4 R9 write count", nw, int'(do_wb) + int'(m[0]));
        if (nw == int'(do_wb) + int'(m[0])) begin
            if (do_wb) begin
                chk(wi[0] === rn && wv[0] === modb, "R2 R4 R9 base write", wv[0], modb);
            end
            if (m[0]) begin
                chk(wi[nw-1] === rd, "R9 dest index", {28'd0, wi[nw-1]}, {28'd0, rd});
                last_val = wv[nw-1];
                chk(last_val === exp_ld, m[1] ? "R6 byte load" : "R5 word load", last_val, exp_ld);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ready === 1'b1 && bus_req === 1'b0 && reg_we === 1'b0 && done === 1'b0,
            "R11 reset state", {28'd0, ready, bus_req, reg_we, done}, 32'h8);
        rst = 0;
        @(negedge clk);
        chk(ready === 1'b1 && done === 1'b0, "R11 after reset", {30'd0, ready, done}, 32'h2);
        for (int mi = 0; mi < 64; mi++) begin
            for (int a = 0; a < 4; a++) begin
                logic [31:0] b;
                logic [3:0]  rd;
                case (a)
                    0: b = 32'h0000_1000;
                    1: b = 32'h0000_0005;
                    2: b = 32'hFFFF_FFFE;
                    default: b = 32'h8000_0103;
                endcase
                rd = ((mi + a) % 2 == 0) ? 4'd3 : 4'd7;
                run_op(6'(mi), b, 12'hFFD - 12'(a * 5), 32'hFFFF_FF00 + 32'(a * 3 + mi),
                       32'h1234_5600 + 32'(mi * 7 + a), 4'd3, rd, (mi + a) % 3);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule